// File: doc/BRIEF.md
# Interrupt Redirection Entry Controller

This block is a single entry of an I/O interrupt routing table. It watches one interrupt line and turns its activity into message interrupt requests. When the entry is masked, it turns the same activity into legacy assert and deassert events. Software programs five fields through a write strobe: mask, trigger mode, polarity, destination mode and vector. The block keeps its own remote-IRR and delivery-status bits.

Requests leave through a valid/ready handshake that carries the vector and the destination mode. Legacy events leave as one-cycle pulses. End-of-interrupt notices arrive with a vector and are matched against the entry's own vector.

The interrupt line first passes through a synchroniser and is then normalised by the polarity bit. Every later rule works on the normalised "active" level.

Top module: `irq_route_entry`

## Requirements
- R1: After reset, `cfg_rd` reads mask=1 and every other field 0, and `msg_valid`, `rirr`, `dlv_status`, `vw_assert` and `vw_deassert` are all 0. The `cfg_rd` layout is [VEC_W+3]=mask, [VEC_W+2]=trigger (1=level, 0=edge), [VEC_W+1]=polarity (1=active low), [VEC_W]=destination mode, [VEC_W-1:0]=vector. A write with `cfg_we` high updates all fields on the next clock.
- R2: With polarity 1, a low pin counts as active and a high pin as inactive. With polarity 0, the opposite holds.
- R3: While the mask is set, no request is raised. An edge seen while masked is lost and is not sent when the mask clears. A request still waiting for ready is withdrawn once the mask has been set.
- R4: In edge mode, with the entry unmasked and bus-master enable high, each inactive-to-active transition raises one request. The request appears on `msg_valid` three clocks after the pin changes, and it carries the entry's vector. An input that stays active does not raise another request.
- R5: While the entry is masked, an activation pulses `vw_assert` for one cycle. A later deactivation pulses `vw_deassert`, but only while an assert is outstanding. The two pulses never occur in the same cycle.
- R6: While `legacy_off` is high, activations and deactivations of a masked entry produce no legacy pulses.
- R7: When the mask goes from 1 to 0, two things can happen. An outstanding assert produces a `vw_deassert` pulse. In level mode, an active input raises a request at once.
- R8: When the mask goes from 0 to 1 with the input active, a `vw_assert` pulse is produced. With the input inactive, no pulse is produced.
- R9: In level mode, `rirr` sets in the cycle after a request is accepted (`msg_valid` and `msg_ready` both high). It stays 0 before acceptance and in edge mode.
- R10: While `rirr` is set, no further request is raised. An end-of-interrupt whose vector differs from the entry's vector is ignored. A matching one clears `rirr`, and on the following clock an active level input raises a new request.
- R11: A request that is not accepted keeps `msg_valid` high, and its vector stays stable, for as long as the entry stays unmasked.
- R12: While `bus_master_en` is low, no new request is raised and `rirr` cannot set. When it rises again, a pending active level is requested on the next clock.
- R13: `dlv_status` follows the active state of the input when the entry is in level mode and unmasked. Otherwise it reads 0.
- R14: `msg_logical` carries the destination-mode bit of the entry (0 physical, 1 logical) with each request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for all entry fields |
| cfg_wmask | input | 1 | New mask bit |
| cfg_wlevel | input | 1 | New trigger mode (1 level) |
| cfg_wlow | input | 1 | New polarity (1 active low) |
| cfg_wlogical | input | 1 | New destination mode (1 logical) |
| cfg_wvector | input | VEC_W | New vector |
| cfg_rd | output | VEC_W+4 | Current field values |
| irq_pin | input | 1 | Interrupt line (asynchronous) |
| legacy_off | input | 1 | Suppresses legacy pulses |
| bus_master_en | input | 1 | Permits new requests |
| eoi_valid | input | 1 | End-of-interrupt notice present |
| eoi_vector | input | VEC_W | Vector of the notice |
| msg_valid | output | 1 | Request pending |
| msg_ready | input | 1 | Request accepted when high with valid |
| msg_vector | output | VEC_W | Vector of the request |
| msg_logical | output | 1 | Destination mode of the request |
| vw_assert | output | 1 | Legacy assert pulse |
| vw_deassert | output | 1 | Legacy deassert pulse |
| rirr | output | 1 | Remote-IRR status |
| dlv_status | output | 1 | Delivery status |

## Verification
A pin change reaches `msg_valid`, `dlv_status` and the legacy pulses after three rising edges: two synchroniser stages plus one output register. A field write lands on the first edge, and its mask-transition pulses or level resample appear one edge later. An end-of-interrupt clears `rirr` on its own edge, and the resampled request follows one edge after that. The bench drives every input on a falling edge, counts the rising edges needed for each result, and samples on the falling edge that follows. Single-cycle pulses are therefore caught in exactly their cycle, and checks of their absence one cycle later confirm the pulse width.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef struct packed {
    logic mask;
    logic level;
    logic active_low;
    logic logical;
  } entry_ctl_t;

  localparam entry_ctl_t CTL_RESET = '{mask: 1'b1, level: 1'b0,
                                       active_low: 1'b0, logical: 1'b0};
endpackage

// File: rtl/irq_pin_front.sv
module irq_pin_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic active_low,
  output logic act,
  output logic rise,
  output logic fall
);
  logic [SYNC_STAGES-1:0] chain;
  logic                   act_d;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= pin;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[SYNC_STAGES-2:0], pin};
      end
    end
  endgenerate

  // normalised level: 1 means the line is asserted
  assign act = chain[SYNC_STAGES-1] ^ active_low;

  always_ff @(posedge clk) begin
    if (rst) act_d <= 1'b0;
    else     act_d <= act;
  end

  assign rise = act & ~act_d;
  assign fall = ~act & act_d;
endmodule

// File: rtl/irq_msg_ctrl.sv
module irq_msg_ctrl #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mask,
  input  logic             level,
  input  logic             logical,
  input  logic [VEC_W-1:0] vector,
  input  logic             act,
  input  logic             rise,
  input  logic             bme,
  input  logic             eoi_valid,
  input  logic [VEC_W-1:0] eoi_vector,
  input  logic             msg_ready,
  output logic             msg_valid,
  output logic [VEC_W-1:0] msg_vector,
  output logic             msg_logical,
  output logic             rirr
);
  logic pend;
  logic issue;
  logic accept;
  logic eoi_hit;

  always_comb begin
    issue   = !mask && bme && !pend && (level ? (act && !rirr) : rise);
    accept  = pend && msg_ready && !mask;
    eoi_hit = eoi_valid && (eoi_vector == vector);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend        <= 1'b0;
      msg_vector  <= '0;
      msg_logical <= 1'b0;
    end else if (mask || accept) begin
      pend <= 1'b0;
    end else if (issue) begin
      pend        <= 1'b1;
      msg_vector  <= vector;
      msg_logical <= logical;
    end
  end

  // acceptance wins over a same-cycle end-of-interrupt
  always_ff @(posedge clk) begin
    if (rst)                  rirr <= 1'b0;
    else if (accept && level) rirr <= 1'b1;
    else if (eoi_hit)         rirr <= 1'b0;
  end

  assign msg_valid = pend;
endmodule

// File: rtl/irq_vw_ctrl.sv
module irq_vw_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic mask,
  input  logic legacy_off,
  input  logic act,
  input  logic rise,
  input  logic fall,
  output logic vw_assert,
  output logic vw_deassert
);
  logic mask_d;
  logic held;
  logic mask_up;
  logic mask_dn;
  logic do_assert;
  logic do_deassert;

  always_comb begin
    mask_up     = mask && !mask_d;
    mask_dn     = !mask && mask_d;
    do_assert   = !legacy_off && !held && mask && (mask_up ? act : rise);
    do_deassert = held && (mask_dn || (mask && fall && !legacy_off));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_d      <= 1'b1;
      held        <= 1'b0;
      vw_assert   <= 1'b0;
      vw_deassert <= 1'b0;
    end else begin
      mask_d      <= mask;
      vw_assert   <= do_assert;
      vw_deassert <= do_deassert;
      if (held) held <= !do_deassert;
      else      held <= do_assert;
    end
  end
endmodule

// File: rtl/irq_route_entry.sv
module irq_route_entry
  import irq_entry_pkg::*;
#(
  parameter int VEC_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic               cfg_wmask,
  input  logic               cfg_wlevel,
  input  logic               cfg_wlow,
  input  logic               cfg_wlogical,
  input  logic [VEC_W-1:0]   cfg_wvector,
  output logic [VEC_W+3:0]   cfg_rd,
  input  logic               irq_pin,
  input  logic               legacy_off,
  input  logic               bus_master_en,
  input  logic               eoi_valid,
  input  logic [VEC_W-1:0]   eoi_vector,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [VEC_W-1:0]   msg_vector,
  output logic               msg_logical,
  output logic               vw_assert,
  output logic               vw_deassert,
  output logic               rirr,
  output logic               dlv_status
);
  localparam int CFG_W = VEC_W + 4;

  entry_ctl_t       ctl;
  logic [VEC_W-1:0] vec_q;
  logic             act;
  logic             rise;
  logic             fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl   <= CTL_RESET;
      vec_q <= '0;
    end else if (cfg_we) begin
      ctl   <= '{mask: cfg_wmask, level: cfg_wlevel,
                 active_low: cfg_wlow, logical: cfg_wlogical};
      vec_q <= cfg_wvector;
    end
  end

  assign cfg_rd = CFG_W'({ctl, vec_q});

  irq_pin_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk        (clk),
    .rst        (rst),
    .pin        (irq_pin),
    .active_low (ctl.active_low),
    .act        (act),
    .rise       (rise),
    .fall       (fall)
  );

  irq_msg_ctrl #(.VEC_W(VEC_W)) u_msg (
    .clk         (clk),
    .rst         (rst),
    .mask        (ctl.mask),
    .level       (ctl.level),
    .logical     (ctl.logical),
    .vector      (vec_q),
    .act         (act),
    .rise        (rise),
    .bme         (bus_master_en),
    .eoi_valid   (eoi_valid),
    .eoi_vector  (eoi_vector),
    .msg_ready   (msg_ready),
    .msg_valid   (msg_valid),
    .msg_vector  (msg_vector),
    .msg_logical (msg_logical),
    .rirr        (rirr)
  );

  irq_vw_ctrl u_vw (
    .clk         (clk),
    .rst         (rst),
    .mask        (ctl.mask),
    .legacy_off  (legacy_off),
    .act         (act),
    .rise        (rise),
    .fall        (fall),
    .vw_assert   (vw_assert),
    .vw_deassert (vw_deassert)
  );

  always_ff @(posedge clk) begin
    if (rst) dlv_status <= 1'b0;
    else     dlv_status <= ctl.level && !ctl.mask && act;
  end
endmodule

// File: rtl/irq_route_entry_chk.sv
module irq_route_entry_chk #(
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             mask_q,
  input logic             level_q,
  input logic             msg_valid,
  input logic             msg_ready,
  input logic [VEC_W-1:0] msg_vector,
  input logic             vw_assert,
  input logic             vw_deassert,
  input logic             rirr,
  input logic             dlv_status,
  input logic             bus_master_en
);
  p_no_valid_masked_r3: assert property (@(posedge clk) disable iff (rst)
    mask_q && $past(mask_q) |-> !msg_valid);

  p_one_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    !(vw_assert && vw_deassert));

  p_rirr_set_r9: assert property (@(posedge clk) disable iff (rst)
    msg_valid && msg_ready && !mask_q && level_q |=> rirr);

  p_rirr_gate_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(msg_valid) && level_q && $past(level_q) |-> !$past(rirr));

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    msg_valid && !msg_ready && !mask_q |=> msg_valid && $stable(msg_vector));

  p_bme_gate_r12: assert property (@(posedge clk) disable iff (rst)
    !bus_master_en && !msg_valid |=> !msg_valid);

  p_dlv_edge_r13: assert property (@(posedge clk) disable iff (rst)
    !level_q && $past(!level_q) |-> !dlv_status);
endmodule

bind irq_route_entry irq_route_entry_chk #(.VEC_W(VEC_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .mask_q        (cfg_rd[VEC_W+3]),
  .level_q       (cfg_rd[VEC_W+2]),
  .msg_valid     (msg_valid),
  .msg_ready     (msg_ready),
  .msg_vector    (msg_vector),
  .vw_assert     (vw_assert),
  .vw_deassert   (vw_deassert),
  .rirr          (rirr),
  .dlv_status    (dlv_status),
  .bus_master_en (bus_master_en)
);

// File: tb/irq_route_entry_test.sv
module irq_route_entry_test;
  localparam int VEC_W   = 8;
  localparam int SYNC    = 2;
  localparam int PIN_LAT = SYNC + 1;

  logic             clk = 1'b0;
  logic             rst;
  logic             cfg_we, cfg_wmask, cfg_wlevel, cfg_wlow, cfg_wlogical;
  logic [VEC_W-1:0] cfg_wvector;
  logic [VEC_W+3:0] cfg_rd;
  logic             irq_pin, legacy_off, bus_master_en;
  logic             eoi_valid;
  logic [VEC_W-1:0] eoi_vector;
  logic             msg_valid, msg_ready, msg_logical;
  logic [VEC_W-1:0] msg_vector;
  logic             vw_assert, vw_deassert, rirr, dlv_status;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  irq_route_entry #(.VEC_W(VEC_W), .SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wmask(cfg_wmask),
    .cfg_wlevel(cfg_wlevel), .cfg_wlow(cfg_wlow), .cfg_wlogical(cfg_wlogical),
    .cfg_wvector(cfg_wvector), .cfg_rd(cfg_rd), .irq_pin(irq_pin),
    .legacy_off(legacy_off), .bus_master_en(bus_master_en),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_vector(msg_vector), .msg_logical(msg_logical),
    .vw_assert(vw_assert), .vw_deassert(vw_deassert), .rirr(rirr),
    .dlv_status(dlv_status)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; cfg_we = 1'b0; cfg_wmask = 1'b1; cfg_wlevel = 1'b0;
    cfg_wlow = 1'b0; cfg_wlogical = 1'b0; cfg_wvector = '0;
    irq_pin = 1'b0; legacy_off = 1'b0; bus_master_en = 1'b1;
    eoi_valid = 1'b0; eoi_vector = '0; msg_ready = 1'b1;
    tick(3);
    rst = 1'b0;
  endtask

  task automatic wcfg(input logic m, input logic l, input logic p,
                      input logic g, input logic [VEC_W-1:0] v);
    cfg_we = 1'b1; cfg_wmask = m; cfg_wlevel = l; cfg_wlow = p;
    cfg_wlogical = g; cfg_wvector = v;
    tick(1);
    cfg_we = 1'b0;
  endtask

  task automatic send_eoi(input logic [VEC_W-1:0] v);
    eoi_valid = 1'b1; eoi_vector = v;
    tick(1);
    eoi_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "cfg_rd after reset", 32'(cfg_rd), 32'h800);
    chk("R1", "msg_valid after reset", 32'(msg_valid), 0);
    chk("R1", "rirr after reset", 32'(rirr), 0);
    chk("R1", "dlv after reset", 32'(dlv_status), 0);
    chk("R1", "vw pulses after reset", 32'({vw_assert, vw_deassert}), 0);
  endtask

  task automatic t_edge();
    do_reset();
    msg_ready = 1'b0;
    wcfg(1'b0, 1'b0, 1'b0, 1'b1, 8'h35);
    chk("R1", "cfg_rd readback", 32'(cfg_rd), 32'h135);
    irq_pin = 1'b1;
    tick(PIN_LAT);
    chk("R4", "edge request valid", 32'(msg_valid), 1);
    chk("R4", "edge request vector", 32'(msg_vector), 32'h35);
    chk("R14", "logical destination", 32'(msg_logical), 1);
    tick(1);
    chk("R11", "edge request held", 32'(msg_valid), 1);
    msg_ready = 1'b1;
    tick(1);
    chk("R4", "accepted request drops", 32'(msg_valid), 0);
    chk("R9", "no rirr in edge mode", 32'(rirr), 0);
    tick(4);
    chk("R4", "steady level no repeat", 32'(msg_valid), 0);
    irq_pin = 1'b0;
    tick(PIN_LAT);
    wcfg(1'b1, 1'b0, 1'b0, 1'b1, 8'h35);
    irq_pin = 1'b1;
    tick(PIN_LAT);
    chk("R3", "masked edge no request", 32'(msg_valid), 0);
    wcfg(1'b0, 1'b0, 1'b0, 1'b1, 8'h35);
    tick(2);
    chk("R3", "masked edge not replayed", 32'(msg_valid), 0);
  endtask

  task automatic t_level();
    do_reset();
    msg_ready = 1'b0;
    wcfg(1'b0, 1'b1, 1'b0, 1'b0, 8'h5A);
    irq_pin = 1'b1;
    tick(PIN_LAT);
    chk("R11", "level request raised", 32'(msg_valid), 1);
    tick(4);
    chk("R11", "level request still held", 32'(msg_valid), 1);
    chk("R11", "held vector stable", 32'(msg_vector), 32'h5A);
    chk("R14", "physical destination", 32'(msg_logical), 0);
    chk("R9", "rirr clear before accept", 32'(rirr), 0);
    msg_ready = 1'b1;
    tick(1);
    chk("R9", "rirr set on accept", 32'(rirr), 1);
    chk("R9", "valid drops on accept", 32'(msg_valid), 0);
    tick(4);
    chk("R10", "no repeat while rirr", 32'(msg_valid), 0);
    send_eoi(8'h5B);
    chk("R10", "mismatched eoi ignored", 32'(rirr), 1);
    tick(2);
    chk("R10", "no request after mismatched eoi", 32'(msg_valid), 0);
    send_eoi(8'h5A);
    chk("R10", "matching eoi clears rirr", 32'(rirr), 0);
    tick(1);
    chk("R10", "resample raises request", 32'(msg_valid), 1);
    tick(1);
    chk("R10", "rirr set again", 32'(rirr), 1);
    irq_pin = 1'b0;
    tick(PIN_LAT);
    send_eoi(8'h5A);
    tick(3);
    chk("R10", "inactive input no request", 32'(msg_valid), 0);
  endtask

  task automatic t_mask_moves();
    do_reset();
    msg_ready = 1'b0;
    wcfg(1'b0, 1'b1, 1'b0, 1'b0, 8'h11);
    irq_pin = 1'b1;
    tick(PIN_LAT);
    chk("R11", "request pending", 32'(msg_valid), 1);
    wcfg(1'b1, 1'b1, 1'b0, 1'b0, 8'h11);
    tick(1);
    chk("R3", "pending request withdrawn", 32'(msg_valid), 0);
    chk("R8", "assert on mask with active input", 32'(vw_assert), 1);
    tick(1);
    chk("R5", "assert pulse one cycle", 32'(vw_assert), 0);
    wcfg(1'b0, 1'b1, 1'b0, 1'b0, 8'h11);
    tick(1);
    chk("R7", "unmask resample request", 32'(msg_valid), 1);
    chk("R7", "unmask deasserts outstanding", 32'(vw_deassert), 1);
  endtask

  task automatic t_vw();
    do_reset();
    tick(2);
    chk("R5", "no pulse idle", 32'(vw_assert), 0);
    irq_pin = 1'b1;
    tick(PIN_LAT);
    chk("R5", "assert pulse on activation", 32'({vw_assert, vw_deassert}), 2);
    tick(1);
    chk("R5", "assert pulse width", 32'(vw_assert), 0);
    irq_pin = 1'b0;
    tick(PIN_LAT);
    chk("R5", "deassert pulse on release", 32'({vw_assert, vw_deassert}), 1);
    legacy_off = 1'b1;
    irq_pin = 1'b1;
    tick(PIN_LAT);
    chk("R6", "assert suppressed", 32'(vw_assert), 0);
    irq_pin = 1'b0;
    tick(PIN_LAT);
    chk("R6", "deassert suppressed", 32'(vw_deassert), 0);
    legacy_off = 1'b0;
    wcfg(1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    wcfg(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    tick(1);
    chk("R8", "mask with inactive input silent",
        32'({vw_assert, vw_deassert}), 0);
  endtask

  task automatic t_polarity();
    do_reset();
    irq_pin = 1'b1;
    tick(PIN_LAT);
    wcfg(1'b0, 1'b1, 1'b1, 1'b0, 8'h77);
    tick(PIN_LAT);
    chk("R2", "high pin inactive when active low", 32'(msg_valid), 0);
    irq_pin = 1'b0;
    tick(PIN_LAT);
    chk("R2", "low pin raises request", 32'(msg_valid), 1);
    chk("R13", "dlv follows active low input", 32'(dlv_status), 1);
  endtask

  task automatic t_bme();
    do_reset();
    bus_master_en = 1'b0;
    wcfg(1'b0, 1'b1, 1'b0, 1'b0, 8'h22);
    irq_pin = 1'b1;
    tick(PIN_LAT + 2);
    chk("R12", "no request with bme low", 32'(msg_valid), 0);
    chk("R12", "rirr stays clear", 32'(rirr), 0);
    bus_master_en = 1'b1;
    tick(1);
    chk("R12", "request after bme rises", 32'(msg_valid), 1);
  endtask

  task automatic t_dlv();
    do_reset();
    wcfg(1'b0, 1'b1, 1'b0, 1'b0, 8'h01);
    irq_pin = 1'b1;
    tick(PIN_LAT);
    chk("R13", "dlv high level unmasked", 32'(dlv_status), 1);
    wcfg(1'b1, 1'b1, 1'b0, 1'b0, 8'h01);
    tick(1);
    chk("R13", "dlv low when masked", 32'(dlv_status), 0);
    wcfg(1'b0, 1'b0, 1'b0, 1'b0, 8'h01);
    tick(1);
    chk("R13", "dlv low in edge mode", 32'(dlv_status), 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
  endtask

  initial begin
    t_reset();
    t_edge();
    t_level();
    t_mask_moves();
    t_vw();
    t_polarity();
    t_bme();
    t_dlv();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: all requirements, actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule